// File: doc/BRIEF.md
# Bus-Width Matching Read Unpacker

The unpacker sits between a queue of 36-bit long words and a read bus that may be narrower. It takes one long word at a time from the source through a valid/ready handshake, holds it, and hands it to the reader as one 36-bit piece, two 18-bit halves or four 9-bit bytes. Each accepted read advances to the next piece; once the last piece has been read the held word is released and the next long word may be taken.

The piece order and the bus size are configuration captured during reset. While `rst_n` is low, the unpacker samples `cfg_big_end` and `cfg_width` on every clock edge. The value present at the last edge before reset is released is then held until the next reset. A captured `cfg_big_end` of 1 delivers the most significant piece first. A value of 0 delivers the least significant piece first. In long-word size the order setting has no effect.

The controller has two states. In `ST_EMPTY` no word is held, `src_ready` is 1 and `rd_valid` is 0. The transition `take` (`src_valid` = 1 in `ST_EMPTY`) loads the word and moves to `ST_HOLD`. In `ST_HOLD`, the transition `step` (read accepted, piece not last) advances the piece counter and stays in `ST_HOLD`. The transition `drain` (read accepted on the last piece) returns to `ST_EMPTY`. Reset forces `ST_EMPTY`.

Top module: `bus_unpacker`

## Requirements
- R1: While `rst_n` is low and directly after its release, `rd_valid` is 0 and `src_ready` is 1.
- R2: `cfg_big_end` and `cfg_width` are sampled only while reset is low. Changing them after release has no effect on piece size or order until the next reset.
- R3: With `cfg_width` = 2'b00 (long word), a single read delivers the whole 36-bit word unchanged for either order setting, and the word is then released.
- R4: With `cfg_width` = 2'b01 (word), a long word takes exactly 2 reads. Each piece sits in `rd_data[17:0]` and bits 35:18 are 0.
- R5: With `cfg_width` = 2'b10 or 2'b11 (byte), a long word takes exactly 4 reads. Each piece sits in `rd_data[8:0]` and bits 35:9 are 0.
- R6: With a captured order of 1 (big-endian), pieces are delivered from most significant to least significant: bits 35:27 first for bytes, bits 35:18 first for words.
- R7: With a captured order of 0 (little-endian), pieces are delivered from least significant to most significant: bits 8:0 first for bytes, bits 17:0 first for words.
- R8: `src_ready` is 1 only while no word is held. A new long word is taken only after the last piece of the previous one has been read.
- R9: `rd_valid` is 0 whenever no word is held. While `rd_valid` is 1 and `rd_en` is 0, `rd_data` and `rd_valid` hold their values.
- R10: `rd_valid` becomes 1 on the clock edge that takes a word (`src_valid` and `src_ready` both 1), and the first piece is on `rd_data` from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; configuration is sampled while it is low |
| cfg_big_end | input | 1 | Piece order select: 1 = most significant first, 0 = least significant first |
| cfg_width | input | 2 | Read bus size: 00 long word, 01 word, 1x byte |
| src_data | input | 36 | Long word offered by the source |
| src_valid | input | 1 | Source offers a long word |
| src_ready | output | 1 | Unpacker is empty and takes a word this cycle |
| rd_en | input | 1 | Reader consumes the current piece |
| rd_data | output | 36 | Current piece, zero-extended |
| rd_valid | output | 1 | A piece is available on `rd_data` |

## Verification
Every result is due one register stage after its cause. A word taken at edge N shows on `rd_data` with `rd_valid` high from edge N. A read accepted at edge N shows the next piece, or the empty state with `src_ready` high, from edge N. Configuration captured during reset is in force from the first edge after release. The bench drives inputs on the falling edge and samples outputs at the next falling edge, half a period after the rising edge that produced them, so each check lands exactly one edge after its stimulus.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
    // bus size encoding as seen on cfg_width
    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_BYTE_ALT = 2'b11
    } size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/unpack_cfg.sv
module unpack_cfg
    import unpack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_big_end,
    input  logic [1:0] cfg_width,
    output logic       big_end_q,
    output size_e      size_q
);
    // Tracks the pins while reset is low; frozen once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_end_q <= cfg_big_end;
            size_q    <= size_e'(cfg_width);
        end
    end
endmodule

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
    import unpack_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] last_idx,
    output logic             src_ready,
    output logic             hold,
    output logic             load,
    output logic [IDX_W-1:0] idx
);
    ctrl_state_e state, state_nx;
    logic [IDX_W-1:0] idx_nx;
    logic is_last;

    assign is_last = (idx == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // next state: take, step, drain
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_EMPTY: begin
                if (src_valid) begin
                    state_nx = ST_HOLD;
                    idx_nx   = '0;
                end
            end
            ST_HOLD: begin
                if (rd_en) begin
                    if (is_last) begin
                        state_nx = ST_EMPTY;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        src_ready = 1'b0;
        hold      = 1'b0;
        load      = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                src_ready = 1'b1;
                load      = src_valid;
            end
            ST_HOLD: hold = 1'b1;
            default: src_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/unpack_mux.sv
module unpack_mux
    import unpack_pkg::*;
#(
    parameter int LONG_W = 36,
    parameter int IDX_W  = 2
) (
    input  logic [LONG_W-1:0] word,
    input  size_e             size,
    input  logic              big_end,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [LONG_W-1:0] piece
);
    localparam int HALF_W = LONG_W / 2;
    localparam int BYTE_W = LONG_W / 4;

    logic [HALF_W-1:0] halves [2];
    logic [BYTE_W-1:0] bytes  [4];
    logic [IDX_W-1:0]  pos;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign halves[h] = word[h*HALF_W +: HALF_W];
    end
    for (genvar b = 0; b < 4; b++) begin : g_byte
        assign bytes[b] = word[b*BYTE_W +: BYTE_W];
    end

    // position of the current piece, counted from the least significant end
    assign pos = big_end ? (last_idx - idx) : idx;

    always_comb begin
        piece = '0;
        unique case (size)
            SZ_LONG: piece = word;
            SZ_HALF: piece[HALF_W-1:0] = halves[pos[0]];
            SZ_BYTE, SZ_BYTE_ALT: piece[BYTE_W-1:0] = bytes[pos[1:0]];
            default: piece = word;
        endcase
    end
endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker
    import unpack_pkg::*;
#(
    parameter int LONG_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_end,
    input  logic [1:0]        cfg_width,
    input  logic [LONG_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              rd_en,
    output logic [LONG_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int IDX_W = 2;

    logic              big_end_q;
    size_e             size_q;
    logic              load;
    logic              hold;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [LONG_W-1:0] word_q;

    unpack_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_big_end(cfg_big_end),
        .cfg_width  (cfg_width),
        .big_end_q  (big_end_q),
        .size_q     (size_q)
    );

    always_comb begin
        unique case (size_q)
            SZ_LONG: last_idx = 2'd0;
            SZ_HALF: last_idx = 2'd1;
            default: last_idx = 2'd3;
        endcase
    end

    unpack_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_valid(src_valid),
        .rd_en    (rd_en),
        .last_idx (last_idx),
        .src_ready(src_ready),
        .hold     (hold),
        .load     (load),
        .idx      (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (load) word_q <= src_data;
    end

    unpack_mux #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_mux (
        .word    (word_q),
        .size    (size_q),
        .big_end (big_end_q),
        .idx     (idx),
        .last_idx(last_idx),
        .piece   (rd_data)
    );

    assign rd_valid = hold;
endmodule

// File: rtl/unpack_chk.sv
module unpack_chk
    import unpack_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        src_valid,
    input logic        src_ready,
    input logic        rd_en,
    input logic        rd_valid,
    input logic [35:0] rd_data,
    input size_e       size_q
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_empty_chk: assert (!rd_valid && src_ready);
        end
    end

    // R8
    ready_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !rd_valid);

    // R10
    take_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> rd_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    // R3
    long_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_en && size_q == SZ_LONG) |=> !rd_valid);

    // R4
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && size_q == SZ_HALF) |-> (rd_data[35:18] == '0));

    // R5
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (size_q == SZ_BYTE || size_q == SZ_BYTE_ALT)) |-> (rd_data[35:9] == '0));
endmodule

bind bus_unpacker unpack_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_valid(src_valid),
    .src_ready(src_ready),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .size_q   (size_q)
);

// File: tb/sim_bus_unpacker.sv
`timescale 1ns/1ps
module sim_bus_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_end = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic [35:0] src_data = '0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic        rd_en = 1'b0;
    logic [35:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bus_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .cfg_big_end(cfg_big_end), .cfg_width(cfg_width),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // expected piece k of a long word from the requirement text
    function automatic logic [35:0] exp_piece(input logic [35:0] w, input logic [1:0] sz,
                                              input bit big, input int k);
        int n;
        int p;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        p = big ? (n - 1 - k) : k;
        if (n == 1) return w;
        if (n == 2) return {18'd0, w[p*18 +: 18]};
        return {27'd0, w[p*9 +: 9]};
    endfunction

    // reset with a configuration; afterwards the pins are flipped (R2)
    task automatic do_reset(input bit big, input logic [1:0] sz);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_big_end = big;
        cfg_width = sz;
        repeat (3) @(negedge clk);
        chk(!rd_valid && src_ready, "R1 in reset", {34'd0, rd_valid, src_ready}, 36'h1);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_big_end = ~big;
        cfg_width = ~sz;
        chk(!rd_valid && src_ready, "R1 after release", {34'd0, rd_valid, src_ready}, 36'h1);
    endtask

    task automatic push(input logic [35:0] w);
        chk(src_ready, "R8 ready when empty", {35'd0, src_ready}, 36'h1);
        src_data = w;
        src_valid = 1'b1;
        @(negedge clk);
        src_valid = 1'b0;
        chk(rd_valid, "R10 valid after take", {35'd0, rd_valid}, 36'h1);
    endtask

    // push one word and read all pieces, checking each
    task automatic run_word(input logic [35:0] w, input bit big, input logic [1:0] sz, input string req);
        int n;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        push(w);
        for (int k = 0; k < n; k++) begin
            chk(rd_valid && rd_data == exp_piece(w, sz, big, k), req, rd_data, exp_piece(w, sz, big, k));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(!rd_valid && src_ready, "R8 R9 released after last piece", {34'd0, rd_valid, src_ready}, 36'h1);
    endtask

    task automatic t_long;
        do_reset(1'b0, 2'b00);
        run_word(36'h9_8765_4321, 1'b0, 2'b00, "R3 long little");
        do_reset(1'b1, 2'b00);
        run_word(36'h9_8765_4321, 1'b0, 2'b00, "R3 long big same word");
    endtask

    task automatic t_half;
        do_reset(1'b1, 2'b01);
        run_word(36'hA_BCDE_F012, 1'b1, 2'b01, "R4 R6 word big");
        do_reset(1'b0, 2'b01);
        run_word(36'hA_BCDE_F012, 1'b0, 2'b01, "R4 R7 word little");
    endtask

    task automatic t_byte;
        do_reset(1'b1, 2'b10);
        run_word(36'h1_2345_6789, 1'b1, 2'b10, "R5 R6 byte big");
        run_word(36'hF_0F0F_5A5A, 1'b1, 2'b10, "R2 R5 R6 byte big after pin change");
        do_reset(1'b0, 2'b11);
        run_word(36'h1_2345_6789, 1'b0, 2'b11, "R5 R7 byte little alt code");
    endtask

    // hold with no reads while the source keeps offering another word
    task automatic t_hold;
        logic [35:0] first;
        do_reset(1'b1, 2'b10);
        push(36'hC_3333_4444);
        first = rd_data;
        src_data = 36'h5_5555_5555;
        src_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!src_ready, "R8 not ready while held", {35'd0, src_ready}, 36'h0);
            chk(rd_valid && rd_data == first, "R9 stable without read", rd_data, first);
        end
        // read all four pieces; the offered word must arrive only after the last
        for (int k = 0; k < 4; k++) begin
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk(!rd_valid && src_ready, "R8 empty after last read", {34'd0, rd_valid, src_ready}, 36'h1);
        @(negedge clk);
        src_valid = 1'b0;
        chk(rd_valid && rd_data == {27'd0, 9'h0AA}, "R8 R10 next word taken", rd_data, {27'd0, 9'h0AA});
    endtask

    initial begin
        t_long;
        t_half;
        t_byte;
        t_hold;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule